// File: doc/BRIEF.md
# Cluster-Head Slotted Polling Controller

This block is the head of one sensor cluster. It runs a fixed, self-timed frame over a small group of member nodes. No member ever asks for the medium, so nothing needs arbitration. A frame runs these phases in order:

1. An alignment phase.
2. A one-cycle poll of every member.
3. One private receive slot for each member that said it has data, taken in ascending member order.
4. A guard gap.
5. A broadcast window toward the members.
6. A free window. In this window a one-word status summary is offered to a central monitor and held until that monitor takes it.

Member data is not stored in the head. It passes straight through to an upstream valid/ready port while the owner's slot is open.

Member data and broadcast data are valid/ready streams. A beat moves on a cycle where valid and ready are both high.

- **Member to upstream:** the head raises `mem_ready_o[k]` only for the owner of the open slot, and only while `rx_ready_i` is high. Back-pressure from upstream therefore reaches the member directly. A slot closes after one beat, or after `SLOT_CYCLES` cycles with no beat, whichever comes first.
- **Broadcast:** the broadcast source sees `bc_in_ready_o` high for the whole broadcast window. The members must take each beat in that same cycle.
- **Status report:** the report port uses valid/ready. The word stays frozen until it is accepted.

Top module: `cluster_poll_head`

## Requirements
- R1: After reset `phase_o` is idle (code 0), and `mem_ready_o`, `bc_in_ready_o` and `rpt_valid_o` are all low.
- R2: Phase codes are idle 0, align 1, poll 2, slot 3, gap 4, broadcast 5, free 6.
  - Idle goes to align when `run_i` is high.
  - A frame then runs align, poll, slot (skipped when no member responded), gap, broadcast, free.
  - Free goes to align if `run_i` is high, otherwise to idle.
- R3: The align, gap and broadcast phases last exactly the cycle count on their configuration input, with 0 treated as 1. The poll phase lasts one cycle.
- R4: `has_data_i` is captured on the last edge of the poll cycle. A member whose bit was low gets no slot and never sees `mem_ready_o` high. With no responders the frame goes straight from poll to gap.
- R5: Responders are served one slot at a time in ascending member index. `mem_ready_o` has at most one bit set.
- R6: During a slot, the owner's valid and data appear on `rx_valid_o` and `rx_data_o`, with its index on `rx_id_o`. One accepted beat closes the slot.
- R7: A slot with no accepted beat within `SLOT_CYCLES` cycles closes empty and sets that member's bit in `timeout_o`. Both a silent member and a stalled upstream cause this. The flags hold until the next poll clears them.
- R8: `bc_in_ready_o` is high only in the broadcast phase. There, `bcast_valid_o` follows `bc_in_valid_i` and `bcast_data_o` equals `bc_in_data_i`. Outside that phase no broadcast beat is issued.
- R9: On entry to the free phase the report is raised. Its layout is:
  - bits [N-1:0]: the responder bitmap;
  - the next `$clog2(N+1)` bits: the responder count;
  - the top bit: the error flag.

  The word stays stable while `rpt_valid_o` is high and `rpt_ready_i` is low.
- R10: The free phase lasts at least its configured count (0 treated as 1). It does not end until the report has been accepted.
- R11: The error flag is sticky. Any slot timeout sets it, and a report handshake clears it, so a later clean frame reports 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| run_i | input | 1 | Allow frames to start |
| cfg_sync_len_i | input | CNT_W | Align phase length in cycles |
| cfg_inst_len_i | input | CNT_W | Gap phase length in cycles |
| cfg_bcast_len_i | input | CNT_W | Broadcast window length in cycles |
| cfg_free_len_i | input | CNT_W | Minimum free window length in cycles |
| phase_o | output | 3 | Current phase code |
| has_data_i | input | N_MEMBERS | Poll answers, one bit per member |
| mem_valid_i | input | N_MEMBERS | Member data valid |
| mem_data_i | input | N_MEMBERS*DATA_W | Member data, member k at slice k |
| mem_ready_o | output | N_MEMBERS | Member data ready (slot grant) |
| rx_valid_o | output | 1 | Upstream member data valid |
| rx_ready_i | input | 1 | Upstream member data ready |
| rx_data_o | output | DATA_W | Upstream member data |
| rx_id_o | output | IDX_W | Index of the member owning the beat |
| timeout_o | output | N_MEMBERS | Per-member empty-slot flags |
| bc_in_valid_i | input | 1 | Broadcast source valid |
| bc_in_ready_o | output | 1 | Broadcast source ready |
| bc_in_data_i | input | DATA_W | Broadcast source data |
| bcast_valid_o | output | 1 | Broadcast beat to members |
| bcast_data_o | output | DATA_W | Broadcast data to members |
| rpt_valid_o | output | 1 | Status report valid |
| rpt_ready_i | input | 1 | Status report ready |
| rpt_word_o | output | RPT_W | Status report word |

## Verification
The assertions rely on several input rules. `has_data_i` is settled at the poll edge. Configuration lengths do not change during a frame. The upstream port never takes a beat unless `rx_valid_o` is high.

The stimulus follows these rules in three ways:
- It changes member answers, member data and lengths only while the block is idle.
- It drives every input just after a rising edge.
- It shapes back-pressure only through `rx_ready_i` and `rpt_ready_i`. Each is either steady or follows a fixed periodic pattern.

One pattern never grants ready at all, so empty slots can be forced without breaking any rule.

// File: rtl/clp_pkg.sv
package clp_pkg;

  typedef enum logic [2:0] {
    PH_IDLE  = 3'd0,
    PH_SYNC  = 3'd1,
    PH_QUERY = 3'd2,
    PH_SLOT  = 3'd3,
    PH_INST  = 3'd4,
    PH_BCAST = 3'd5,
    PH_FREE  = 3'd6
  } phase_e;

  function automatic int idx_width(input int n);
    return (n > 1) ? $clog2(n) : 1;
  endfunction

  function automatic int cnt_width(input int n);
    return $clog2(n + 1);
  endfunction

endpackage

// File: rtl/clp_phase_timer.sv
module clp_phase_timer #(
  parameter int CNT_W = 12
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             clear_i,
  input  logic [CNT_W-1:0] len_i,
  output logic             done_o
);

  logic [CNT_W-1:0] cnt_q;
  logic [CNT_W:0]   cnt_inc;

  assign cnt_inc = {1'b0, cnt_q} + {{CNT_W{1'b0}}, 1'b1};
  // last cycle of a window; a zero length behaves as one cycle
  assign done_o  = (cnt_inc >= {1'b0, len_i});

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)        cnt_q <= '0;
    else if (clear_i)  cnt_q <= '0;
    else if (!done_o)  cnt_q <= cnt_inc[CNT_W-1:0];
  end

endmodule

// File: rtl/clp_lowest_pick.sv
module clp_lowest_pick #(
  parameter int N     = 4,
  parameter int IDX_W = 2
) (
  input  logic [N-1:0]     req_i,
  output logic [N-1:0]     grant_o,
  output logic [IDX_W-1:0] idx_o
);

  for (genvar g = 0; g < N; g++) begin : g_gnt
    if (g == 0) begin : g_first
      assign grant_o[g] = req_i[g];
    end else begin : g_rest
      assign grant_o[g] = req_i[g] & ~(|req_i[g-1:0]);
    end
  end

  always_comb begin
    idx_o = '0;
    for (int i = 0; i < N; i++) begin
      if (grant_o[i]) idx_o = IDX_W'(i);
    end
  end

endmodule

// File: rtl/clp_report.sv
module clp_report #(
  parameter int N     = 4,
  parameter int CW    = 3,
  parameter int RPT_W = 8
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             load_i,
  input  logic [N-1:0]     map_i,
  input  logic             err_i,
  input  logic             ready_i,
  output logic             valid_o,
  output logic [RPT_W-1:0] word_o
);

  logic [CW-1:0] ones;

  always_comb begin
    ones = '0;
    for (int i = 0; i < N; i++) ones = ones + CW'(map_i[i]);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      valid_o <= 1'b0;
      word_o  <= '0;
    end else if (load_i) begin
      valid_o <= 1'b1;
      word_o  <= {err_i, ones, map_i};
    end else if (valid_o && ready_i) begin
      valid_o <= 1'b0;
    end
  end

endmodule

// File: rtl/cluster_poll_head.sv
module cluster_poll_head
  import clp_pkg::*;
#(
  parameter int N_MEMBERS   = 4,
  parameter int DATA_W      = 16,
  parameter int CNT_W       = 12,
  parameter int SLOT_CYCLES = 4,
  parameter int IDX_W       = clp_pkg::idx_width(N_MEMBERS),
  parameter int RPT_W       = N_MEMBERS + clp_pkg::cnt_width(N_MEMBERS) + 1
) (
  input  logic                          clk,
  input  logic                          rst_n,
  input  logic                          run_i,
  input  logic [CNT_W-1:0]              cfg_sync_len_i,
  input  logic [CNT_W-1:0]              cfg_inst_len_i,
  input  logic [CNT_W-1:0]              cfg_bcast_len_i,
  input  logic [CNT_W-1:0]              cfg_free_len_i,
  output logic [2:0]                    phase_o,
  input  logic [N_MEMBERS-1:0]          has_data_i,
  input  logic [N_MEMBERS-1:0]          mem_valid_i,
  input  logic [N_MEMBERS*DATA_W-1:0]   mem_data_i,
  output logic [N_MEMBERS-1:0]          mem_ready_o,
  output logic                          rx_valid_o,
  input  logic                          rx_ready_i,
  output logic [DATA_W-1:0]             rx_data_o,
  output logic [IDX_W-1:0]              rx_id_o,
  output logic [N_MEMBERS-1:0]          timeout_o,
  input  logic                          bc_in_valid_i,
  output logic                          bc_in_ready_o,
  input  logic [DATA_W-1:0]             bc_in_data_i,
  output logic                          bcast_valid_o,
  output logic [DATA_W-1:0]             bcast_data_o,
  output logic                          rpt_valid_o,
  input  logic                          rpt_ready_i,
  output logic [RPT_W-1:0]              rpt_word_o
);

  localparam int CW = clp_pkg::cnt_width(N_MEMBERS);
  localparam logic [CNT_W-1:0] SLOT_LEN = CNT_W'(SLOT_CYCLES);

  phase_e                 ph_q, ph_d;
  logic [N_MEMBERS-1:0]   pend_q, resp_q, tmo_q;
  logic                   err_q;
  logic                   t_done, t_clear;
  logic [CNT_W-1:0]       t_len;
  logic [N_MEMBERS-1:0]   cur_oh, rest_pend;
  logic [IDX_W-1:0]       cur_idx;
  logic                   in_slot, cur_valid, slot_hs, slot_end, slot_empty;
  logic                   rpt_load, rpt_hs;

  clp_phase_timer #(.CNT_W(CNT_W)) u_timer (
    .clk     (clk),
    .rst_n   (rst_n),
    .clear_i (t_clear),
    .len_i   (t_len),
    .done_o  (t_done)
  );

  clp_lowest_pick #(.N(N_MEMBERS), .IDX_W(IDX_W)) u_pick (
    .req_i   (pend_q),
    .grant_o (cur_oh),
    .idx_o   (cur_idx)
  );

  always_comb begin
    unique case (ph_q)
      PH_SYNC:  t_len = cfg_sync_len_i;
      PH_INST:  t_len = cfg_inst_len_i;
      PH_BCAST: t_len = cfg_bcast_len_i;
      PH_FREE:  t_len = cfg_free_len_i;
      PH_SLOT:  t_len = SLOT_LEN;
      default:  t_len = '0;
    endcase
  end

  // slot datapath: straight pass-through from the slot owner
  assign in_slot    = (ph_q == PH_SLOT);
  assign cur_valid  = |(mem_valid_i & cur_oh);
  assign mem_ready_o = in_slot ? (cur_oh & {N_MEMBERS{rx_ready_i}}) : '0;
  assign rx_valid_o = in_slot & cur_valid;
  assign rx_data_o  = mem_data_i[cur_idx*DATA_W +: DATA_W];
  assign rx_id_o    = cur_idx;
  assign slot_hs    = rx_valid_o & rx_ready_i;
  assign slot_end   = in_slot & (slot_hs | t_done);
  assign slot_empty = in_slot & t_done & ~slot_hs;
  assign rest_pend  = pend_q & ~cur_oh;

  // broadcast pass-through
  assign bc_in_ready_o = (ph_q == PH_BCAST);
  assign bcast_valid_o = bc_in_ready_o & bc_in_valid_i;
  assign bcast_data_o  = bc_in_data_i;

  assign rpt_hs = rpt_valid_o & rpt_ready_i;

  always_comb begin
    ph_d = ph_q;
    unique case (ph_q)
      PH_IDLE:  if (run_i) ph_d = PH_SYNC;
      PH_SYNC:  if (t_done) ph_d = PH_QUERY;
      PH_QUERY: ph_d = (|has_data_i) ? PH_SLOT : PH_INST;
      PH_SLOT:  if (slot_end && rest_pend == '0) ph_d = PH_INST;
      PH_INST:  if (t_done) ph_d = PH_BCAST;
      PH_BCAST: if (t_done) ph_d = PH_FREE;
      PH_FREE:  if (t_done && (!rpt_valid_o || rpt_ready_i))
                  ph_d = run_i ? PH_SYNC : PH_IDLE;
      default:  ph_d = PH_IDLE;
    endcase
  end

  assign t_clear  = (ph_d != ph_q) | slot_end;
  assign rpt_load = (ph_q == PH_BCAST) && (ph_d == PH_FREE);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ph_q   <= PH_IDLE;
      pend_q <= '0;
      resp_q <= '0;
      tmo_q  <= '0;
      err_q  <= 1'b0;
    end else begin
      ph_q <= ph_d;
      if (ph_q == PH_QUERY) begin
        resp_q <= has_data_i;
        pend_q <= has_data_i;
        tmo_q  <= '0;
      end else if (slot_end) begin
        pend_q <= rest_pend;
        if (slot_empty) tmo_q <= tmo_q | cur_oh;
      end
      if (slot_empty)  err_q <= 1'b1;
      else if (rpt_hs) err_q <= 1'b0;
    end
  end

  clp_report #(.N(N_MEMBERS), .CW(CW), .RPT_W(RPT_W)) u_rpt (
    .clk     (clk),
    .rst_n   (rst_n),
    .load_i  (rpt_load),
    .map_i   (resp_q),
    .err_i   (err_q),
    .ready_i (rpt_ready_i),
    .valid_o (rpt_valid_o),
    .word_o  (rpt_word_o)
  );

  assign phase_o   = ph_q;
  assign timeout_o = tmo_q;

endmodule

// File: rtl/cluster_poll_head_chk.sv
module cluster_poll_head_chk
  import clp_pkg::*;
#(
  parameter int N_MEMBERS = 4,
  parameter int RPT_W     = 8
) (
  input logic                 clk,
  input logic                 rst_n,
  input logic [2:0]           phase_o,
  input logic [N_MEMBERS-1:0] mem_ready_o,
  input logic [N_MEMBERS-1:0] resp_map,
  input logic                 rpt_valid_o,
  input logic                 rpt_ready_i,
  input logic [RPT_W-1:0]     rpt_word_o
);

  a_r2_sync_then_query: assert property (@(posedge clk) disable iff (!rst_n)
    (phase_o == PH_SYNC) |=> (phase_o == PH_SYNC || phase_o == PH_QUERY));

  a_r3_query_one_cycle: assert property (@(posedge clk) disable iff (!rst_n)
    (phase_o == PH_QUERY) |=> (phase_o != PH_QUERY));

  a_r4_no_grant_to_silent: assert property (@(posedge clk) disable iff (!rst_n)
    (phase_o == PH_SLOT) |-> ((mem_ready_o & ~resp_map) == '0));

  a_r5_single_grant: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(mem_ready_o));

  a_r9_report_held: assert property (@(posedge clk) disable iff (!rst_n)
    (rpt_valid_o && !rpt_ready_i) |=> (rpt_valid_o && $stable(rpt_word_o)));

  a_r10_free_waits_ack: assert property (@(posedge clk) disable iff (!rst_n)
    (phase_o == PH_FREE && rpt_valid_o && !rpt_ready_i) |=> (phase_o == PH_FREE));

endmodule

bind cluster_poll_head cluster_poll_head_chk #(
  .N_MEMBERS (N_MEMBERS),
  .RPT_W     (RPT_W)
) u_chk (
  .clk         (clk),
  .rst_n       (rst_n),
  .phase_o     (phase_o),
  .mem_ready_o (mem_ready_o),
  .resp_map    (resp_q),
  .rpt_valid_o (rpt_valid_o),
  .rpt_ready_i (rpt_ready_i),
  .rpt_word_o  (rpt_word_o)
);

// File: tb/cluster_poll_head_bench.sv
module cluster_poll_head_bench;

  localparam int N     = 4;
  localparam int DW    = 16;
  localparam int CNTW  = 12;
  localparam int IDW   = 2;
  localparam int RPT_W = 8;
  localparam int WATCHDOG = 150000;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic run_i = 1'b0;
  logic [CNTW-1:0] cfg_sync = '0, cfg_inst = '0, cfg_bcast = '0, cfg_free = '0;
  logic [2:0] phase_o;
  logic [N-1:0] has_data_i = '0, mem_valid_i = '0, mem_ready_o, timeout_o;
  logic [N*DW-1:0] mem_data_i = '0;
  logic rx_valid_o, rx_ready_i = 1'b1;
  logic [DW-1:0] rx_data_o;
  logic [IDW-1:0] rx_id_o;
  logic bc_in_valid_i = 1'b1, bc_in_ready_o, bcast_valid_o;
  logic [DW-1:0] bc_in_data_i = '0, bcast_data_o;
  logic rpt_valid_o, rpt_ready_i = 1'b1;
  logic [RPT_W-1:0] rpt_word_o;

  always #2 clk = ~clk;

  cluster_poll_head #(.N_MEMBERS(N), .DATA_W(DW), .CNT_W(CNTW), .SLOT_CYCLES(4))
  u_cluster_poll_head (
    .clk(clk), .rst_n(rst_n), .run_i(run_i),
    .cfg_sync_len_i(cfg_sync), .cfg_inst_len_i(cfg_inst),
    .cfg_bcast_len_i(cfg_bcast), .cfg_free_len_i(cfg_free),
    .phase_o(phase_o), .has_data_i(has_data_i), .mem_valid_i(mem_valid_i),
    .mem_data_i(mem_data_i), .mem_ready_o(mem_ready_o),
    .rx_valid_o(rx_valid_o), .rx_ready_i(rx_ready_i), .rx_data_o(rx_data_o),
    .rx_id_o(rx_id_o), .timeout_o(timeout_o),
    .bc_in_valid_i(bc_in_valid_i), .bc_in_ready_o(bc_in_ready_o),
    .bc_in_data_i(bc_in_data_i), .bcast_valid_o(bcast_valid_o),
    .bcast_data_o(bcast_data_o), .rpt_valid_o(rpt_valid_o),
    .rpt_ready_i(rpt_ready_i), .rpt_word_o(rpt_word_o)
  );

  int n_chk = 0, n_fail = 0;
  int stall_mode = 0, hold_rpt = 0, tick = 0;
  logic [N-1:0] cur_has = '0;
  logic monitor_on = 1'b0, done = 1'b0;
  logic [IDW+DW-1:0] rx_q[$];
  logic [RPT_W+N-1:0] rpt_q[$];

  task automatic chk(input string tag, input logic [63:0] act, input logic [63:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: actual %0h expected %0h", tag, act, exp);
    end
  endtask

  function automatic int eff(input logic [CNTW-1:0] v);
    return (v == 0) ? 1 : int'(v);
  endfunction

  task automatic step();
    @(posedge clk);
    #1;
  endtask

  // free-running input patterns for back-pressure and broadcast payload
  initial begin
    forever begin
      @(posedge clk);
      #1;
      tick++;
      rx_ready_i   = (stall_mode == 0) ? 1'b1 :
                     (stall_mode == 1) ? ((tick % 3) == 0) : 1'b0;
      rpt_ready_i  = (hold_rpt == 0) ? 1'b1 : ((tick % 8) == 0);
      bc_in_data_i = DW'(tick * 7);
    end
  end

  // monitor / scoreboard
  logic [2:0] prev_ph = 3'd0;
  int run_len = 0, bc_cnt = 0, bc_bad = 0, bad_ready = 0;
  logic acked = 1'b0;

  always @(negedge clk) begin
    if (monitor_on) begin
      if (rx_valid_o && rx_ready_i) begin
        if (rx_q.size() == 0) chk("R6 unexpected member beat", 64'(rx_id_o), 64'hF);
        else chk("R5 R6 member beat order id/data", 64'({rx_id_o, rx_data_o}), 64'(rx_q.pop_front()));
      end
      if (rpt_valid_o && rpt_ready_i) begin
        acked = 1'b1;
        if (rpt_q.size() == 0) chk("R9 unexpected report", 64'(rpt_word_o), 64'hFFFF);
        else chk("R7 R9 R11 report word and timeout flags",
                 64'({rpt_word_o, timeout_o}), 64'(rpt_q.pop_front()));
      end
      if (bcast_valid_o) bc_cnt++;
      if (bcast_valid_o && bcast_data_o !== bc_in_data_i) bc_bad++;
      if ((mem_ready_o & ~cur_has) != '0) bad_ready++;

      if (phase_o != prev_ph) begin
        case (prev_ph)
          3'd0: chk("R2 idle exit", 64'(phase_o), 64'd1);
          3'd1: begin
            chk("R3 align length", 64'(run_len), 64'(eff(cfg_sync)));
            chk("R2 align then poll", 64'(phase_o), 64'd2);
          end
          3'd2: begin
            chk("R3 poll length", 64'(run_len), 64'd1);
            chk("R4 poll exit", 64'(phase_o), (cur_has != '0) ? 64'd3 : 64'd4);
          end
          3'd3: chk("R2 slots then gap", 64'(phase_o), 64'd4);
          3'd4: begin
            chk("R3 gap length", 64'(run_len), 64'(eff(cfg_inst)));
            chk("R2 gap then broadcast", 64'(phase_o), 64'd5);
          end
          3'd5: begin
            chk("R3 broadcast length", 64'(run_len), 64'(eff(cfg_bcast)));
            chk("R2 broadcast then free", 64'(phase_o), 64'd6);
          end
          3'd6: begin
            chk("R10 free lasted its minimum", 64'(run_len >= eff(cfg_free)), 64'd1);
            chk("R10 free ended after report ack", 64'(acked), 64'd1);
            chk("R2 free exit target", 64'(phase_o == 3'd1 || phase_o == 3'd0), 64'd1);
            chk("R8 broadcast beats per frame", 64'(bc_cnt), 64'(eff(cfg_bcast)));
            chk("R8 broadcast data pass-through", 64'(bc_bad), 64'd0);
            chk("R4 no grant to silent member", 64'(bad_ready), 64'd0);
            bc_cnt = 0; bc_bad = 0; bad_ready = 0; acked = 1'b0;
          end
          default: chk("R2 illegal phase", 64'(prev_ph), 64'd0);
        endcase
        run_len = 1;
        prev_ph = phase_o;
      end else begin
        run_len++;
      end
    end
  end

  // watchdog
  initial begin
    for (int c = 0; c < WATCHDOG; c++) @(posedge clk);
    if (!done) begin
      n_chk++;
      n_fail++;
      $display("FAIL watchdog: actual hung expected finish");
      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
      $finish;
    end
  end

  task automatic do_frame(input logic [N-1:0] has, input logic [N-1:0] vld,
                          input int stall, input int hold,
                          input int s, input int i, input int b, input int f,
                          input int seed, input int frames);
    logic [N-1:0] tmo;
    logic [DW-1:0] d;
    has_data_i  = has;
    mem_valid_i = vld;
    cur_has     = has;
    stall_mode  = stall;
    hold_rpt    = hold;
    cfg_sync = CNTW'(s); cfg_inst = CNTW'(i); cfg_bcast = CNTW'(b); cfg_free = CNTW'(f);
    tmo = (stall == 2) ? has : (has & ~vld);
    for (int fr = 0; fr < frames; fr++) begin
      for (int k = 0; k < N; k++) begin
        d = DW'(16'hA000 + k * 16'h0111 + seed);
        mem_data_i[k*DW +: DW] = d;
        if (has[k] && vld[k] && stall != 2) rx_q.push_back({IDW'(k), d});
      end
      rpt_q.push_back({(tmo != '0), 3'($countones(has)), has, tmo});
    end
    step();
    run_i = 1'b1;
    if (frames == 1) begin
      while (phase_o == 3'd0) step();
      run_i = 1'b0;
    end else begin
      while (phase_o != 3'd2) step();
      while (phase_o != 3'd1) step();
      run_i = 1'b0;
    end
    while (phase_o != 3'd0) step();
    step(); step();
  endtask

  initial begin
    step(); step();
    rst_n = 1'b1;
    @(negedge clk);
    chk("R1 reset phase idle", 64'(phase_o), 64'd0);
    chk("R1 reset no member grant", 64'(mem_ready_o), 64'd0);
    chk("R1 reset no broadcast ready", 64'(bc_in_ready_o), 64'd0);
    chk("R1 reset no report", 64'(rpt_valid_o), 64'd0);
    monitor_on = 1'b1;
    step();

    do_frame(4'b1111, 4'b1111, 0, 0, 3, 2, 4, 3, 1, 1);  // all respond
    do_frame(4'b0101, 4'b0101, 0, 0, 0, 0, 0, 0, 2, 1);  // zero lengths, gaps
    do_frame(4'b0000, 4'b0000, 0, 0, 2, 1, 2, 1, 3, 1);  // nobody answers
    do_frame(4'b1011, 4'b0011, 0, 0, 1, 3, 2, 2, 4, 1);  // R7 member 3 silent
    do_frame(4'b0010, 4'b0010, 0, 0, 2, 2, 3, 2, 5, 1);  // R11 error cleared
    do_frame(4'b1110, 4'b1110, 1, 0, 2, 1, 1, 1, 6, 1);  // upstream stall
    do_frame(4'b0011, 4'b0011, 2, 0, 1, 1, 2, 1, 7, 1);  // R7 stalled to timeout
    do_frame(4'b1001, 4'b1001, 0, 1, 2, 2, 2, 2, 8, 1);  // R10 report held
    do_frame(4'b0110, 4'b0110, 0, 0, 2, 1, 3, 2, 9, 2);  // back-to-back frames

    @(negedge clk);
    chk("R2 idle when run low", 64'(phase_o), 64'd0);
    chk("R6 all member beats seen", 64'(rx_q.size()), 64'd0);
    chk("R9 all reports seen", 64'(rpt_q.size()), 64'd0);
    chk("R8 no broadcast ready in idle", 64'(bc_in_ready_o), 64'd0);
    done = 1'b1;
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end

endmodule